// File: doc/BRIEF.md
# Dual-Clock FIFO with Strap-Selected Read Interface

This block buffers 18-bit words between two unrelated clock domains. The producer side runs on its own write clock and uses a valid/ready handshake. A word is taken on any write-clock edge where `wr_valid` and `wr_ready` are both high. When the memory is full, `wr_ready` falls. A word offered while `wr_ready` is low is simply not taken, and the producer may hold or change it as it likes. The consumer side runs on the read clock and uses a plain read enable with a status flag. Pointers cross between the domains as Gray code through two-flop synchronizers.

Three strap bits are sampled on the read clock while reset is held low, and they choose one of two read interfaces. In standard mode, `empty` reports status, and a word reaches the output register only on a read-clock edge with `rd_en` high and `empty` low. In fall-through mode, the oldest word is loaded into the output register without any request, and `out_rdy` goes high. A read with `out_rdy` high consumes the displayed word. The data bus `q` is driven only while `out_en` is high.

Top module: `dual_clock_fifo`

## Requirements
- R1: Words leave in the order they were written, unchanged, for any power-of-two `DEPTH` of at least 4 (default 256, intended 256 to 4096). In standard mode the block holds exactly `DEPTH` words.
- R2: The strap is read as {fl, rxi, wxi} = `mode_strap[2:0]` while `rst_n` is low. The codes 3'b010 and 3'b110 select fall-through mode. Every other code, including 3'b001 and 3'b101, selects standard mode.
- R3: A write offered while `wr_ready` is low is ignored. It changes neither the stored contents nor the order of words.
- R4: In standard mode `empty` is high after reset. After a write into an empty FIFO, `empty` falls on the third read-clock edge after the write edge. It falls one edge later when that first read edge comes too close to the write edge.
- R5: In standard mode, a read-clock edge with `rd_en` high and `empty` low places the oldest word on `q` after that edge. `empty` rises once the last word has been read.
- R6: In standard mode, `q` keeps its value on edges without an accepted read. A read while `empty` is high is ignored and does not disturb the read pointer.
- R7: In fall-through mode, the first word written into an empty FIFO appears on `q` with no `rd_en`. `out_rdy` then rises on the fourth read-clock edge after the write edge, or the fifth when the skew is too small.
- R8: In fall-through mode, `rd_en` high with `out_rdy` high pops the displayed word. On the same edge the next word is loaded, or `out_rdy` falls if nothing is stored.
- R9: In fall-through mode, `rd_en` while `out_rdy` is low is ignored. While `out_rdy` is high and `rd_en` is low, `q` and `out_rdy` hold. In this mode the output register adds one slot, giving a capacity of `DEPTH`+1.
- R10: With `out_en` low, `q` is not driven. `out_en` has no effect on the flags or the stored words.
- R11: `empty` stays high in fall-through mode, and `out_rdy` stays low in standard mode.
- R12: `wr_ready` falls on the write edge that stores the last free entry. It rises again after a read frees an entry and the read pointer has crossed into the write domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rst_n | input | 1 | Active-low reset shared by both domains |
| wr_valid | input | 1 | Producer offers `wr_data` |
| wr_data | input | 18 | Word offered for writing |
| wr_ready | output | 1 | FIFO can take a word (not full) |
| rclk | input | 1 | Read clock |
| rd_en | input | 1 | Read request / pop |
| empty | output | 1 | Standard-mode empty flag |
| out_rdy | output | 1 | Fall-through-mode output-ready flag |
| out_en | input | 1 | Drives `q` when high, high impedance when low |
| q | output | 18 | Output register onto the data bus |
| mode_strap | input | 3 | {fl, rxi, wxi} mode code, sampled during reset |

## Verification
The assertions assume that `rst_n` is held low for at least one edge of each clock, with `mode_strap` steady over that time, so the latched mode never changes after release. They also assume both clocks toggle throughout, and that `rd_en` and `wr_valid` are settled away from their own clock edges. The stimulus holds reset for several edges of both clocks with the strap fixed. It changes write-side inputs on falling `wclk` and read-side inputs on falling `rclk`. The clock periods are chosen so that those drive points never meet an active edge of the same domain. Flag latencies are checked against a window that allows for the one-edge skew penalty.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int unsigned DATA_W = 18;

  typedef enum logic {
    RD_STD  = 1'b0,
    RD_FWFT = 1'b1
  } rd_mode_e;

  // strap = {fl, rxi, wxi}; rxi high with wxi low picks fall-through
  function automatic rd_mode_e decode_strap(input logic [2:0] strap);
    return (strap[1:0] == 2'b10) ? RD_FWFT : RD_STD;
  endfunction
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int unsigned DW = 18,
  parameter int unsigned AW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned N = 1 << AW;

  logic [DW-1:0] mem [N];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl #(
  parameter int unsigned AW = 8
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW:0]   rptr_sync,
  output logic          wr_ready,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wptr_gray
);
  logic [AW:0] wbin, wbin_nx, wgray_nx, full_pat;
  logic        full_q;

  assign we       = wr_valid && !full_q;
  assign wbin_nx  = wbin + {{AW{1'b0}}, we};
  assign wgray_nx = (wbin_nx >> 1) ^ wbin_nx;
  assign full_pat = {~rptr_sync[AW:AW-1], rptr_sync[AW-2:0]};

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin      <= '0;
      wptr_gray <= '0;
      full_q    <= 1'b0;
    end else begin
      wbin      <= wbin_nx;
      wptr_gray <= wgray_nx;
      full_q    <= (wgray_nx == full_pat);
    end
  end

  assign wr_ready = !full_q;
  assign waddr    = wbin[AW-1:0];

  // R3: an offer against a full FIFO must not advance the write pointer
  p_full_blocks_r3: assert property (@(posedge wclk) disable iff (!rst_n)
    (full_q && wr_valid) |=> $stable(wbin));

  // R1: the pointer sent across domains changes by at most one bit per edge
  p_gray_step_r1: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(wptr_gray ^ $past(wptr_gray)) <= 1);
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int unsigned DW = 18,
  parameter int unsigned AW = 8
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic [2:0]    mode_strap,
  input  logic          rd_en,
  input  logic [AW:0]   wptr_sync,
  input  logic [DW-1:0] ram_data,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rptr_gray,
  output logic [DW-1:0] q_word,
  output logic          empty,
  output logic          out_rdy
);
  rd_mode_e    mode_q;
  logic        fwft, take, mem_empty, or_q;
  logic [AW:0] rbin, rbin_nx, rgray_nx;

  // strap is captured on every read edge while reset is held
  always_ff @(posedge rclk) begin
    if (!rst_n) mode_q <= decode_strap(mode_strap);
  end

  assign fwft     = (mode_q == RD_FWFT);
  assign take     = fwft ? (!mem_empty && (!or_q || rd_en))
                         : (rd_en && !mem_empty);
  assign rbin_nx  = rbin + {{AW{1'b0}}, take};
  assign rgray_nx = (rbin_nx >> 1) ^ rbin_nx;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin      <= '0;
      rptr_gray <= '0;
      mem_empty <= 1'b1;
    end else begin
      rbin      <= rbin_nx;
      rptr_gray <= rgray_nx;
      mem_empty <= (rgray_nx == wptr_sync);
    end
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      q_word <= '0;
    end else if (take) begin
      q_word <= ram_data;
    end
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n)      or_q <= 1'b0;
    else if (!fwft)  or_q <= 1'b0;
    else if (take)   or_q <= 1'b1;
    else if (rd_en)  or_q <= 1'b0;
  end

  assign raddr   = rbin[AW-1:0];
  assign empty   = fwft ? 1'b1 : mem_empty;
  assign out_rdy = or_q;

  // R2: the latched mode never moves once reset is released
  p_mode_fixed_r2: assert property (@(posedge rclk) disable iff (!rst_n)
    1'b1 |=> $stable(mode_q));

  // R6: a standard-mode read against an empty FIFO leaves the pointer alone
  p_no_underflow_r6: assert property (@(posedge rclk) disable iff (!rst_n)
    (!fwft && empty && rd_en) |=> $stable(rbin));

  // R6: standard-mode output holds without an accepted read
  p_std_hold_r6: assert property (@(posedge rclk) disable iff (!rst_n)
    (!fwft && !(rd_en && !empty)) |=> $stable(q_word));

  // R9: a displayed fall-through word waits for a request
  p_fwft_hold_r9: assert property (@(posedge rclk) disable iff (!rst_n)
    (fwft && out_rdy && !rd_en) |=> ($stable(q_word) && out_rdy));

  // R11: standard mode never raises the output-ready flag
  p_std_no_ready_r11: assert property (@(posedge rclk) disable iff (!rst_n)
    (!fwft) |=> !out_rdy);
endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo
  import dcf_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned DW    = DATA_W
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  input  logic          rclk,
  input  logic          rd_en,
  output logic          empty,
  output logic          out_rdy,
  input  logic          out_en,
  output logic [DW-1:0] q,
  input  logic [2:0]    mode_strap
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic          we;
  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   wgray, rgray, wgray_r, rgray_w;
  logic [DW-1:0] ram_q, q_word;

  dcf_wr_ctl #(.AW(AW)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .wr_valid(wr_valid), .rptr_sync(rgray_w),
    .wr_ready(wr_ready), .we(we), .waddr(waddr), .wptr_gray(wgray)
  );

  dcf_sync #(.W(AW+1)) u_w2r (.clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_r));
  dcf_sync #(.W(AW+1)) u_r2w (.clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_w));

  dcf_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(ram_q)
  );

  dcf_rd_ctl #(.DW(DW), .AW(AW)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .mode_strap(mode_strap), .rd_en(rd_en),
    .wptr_sync(wgray_r), .ram_data(ram_q), .raddr(raddr), .rptr_gray(rgray),
    .q_word(q_word), .empty(empty), .out_rdy(out_rdy)
  );

  assign q = out_en ? q_word : {DW{1'bz}};
endmodule

// File: tb/sim_dual_clock_fifo.sv
`timescale 1ns/1ps
module sim_dual_clock_fifo;
  localparam int DEPTH = 256;

  logic        wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic        wr_valid = 1'b0, rd_en = 1'b0, out_en = 1'b1;
  logic [17:0] wr_data = '0;
  logic [2:0]  mode_strap = 3'b001;
  wire  [17:0] q;
  logic        wr_ready, empty, out_rdy;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 wclk = ~wclk;
  initial begin
    #1;
    forever #3.5 rclk = ~rclk;
  end

  dual_clock_fifo #(.DEPTH(DEPTH)) u0 (
    .wclk(wclk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .rclk(rclk), .rd_en(rd_en), .empty(empty),
    .out_rdy(out_rdy), .out_en(out_en), .q(q), .mode_strap(mode_strap)
  );

  function automatic logic [17:0] pat(input int i);
    return 18'((i * 1031 + 77) ^ (i << 7));
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] code);
    rst_n = 1'b0; mode_strap = code; wr_valid = 1'b0; rd_en = 1'b0;
    repeat (3) @(posedge rclk);
    repeat (3) @(posedge wclk);
    @(negedge rclk); rst_n = 1'b1;
    repeat (2) @(negedge rclk);
  endtask

  task automatic write_one(input logic [17:0] d);
    @(negedge wclk); wr_valid = 1'b1; wr_data = d;
    @(negedge wclk); wr_valid = 1'b0;
  endtask

  task automatic redges(input int n);
    repeat (n) @(posedge rclk);
    #1;
  endtask

  // writes pattern words from index 0 until either n are taken or 40 idle edges pass
  task automatic fill(input int n, output int taken);
    int idle = 0;
    bit acc;
    taken = 0;
    @(negedge wclk); wr_valid = 1'b1; wr_data = pat(0);
    while (taken < n && idle < 40) begin
      acc = wr_ready;
      @(negedge wclk);
      if (acc) begin taken++; wr_data = pat(taken); idle = 0; end
      else idle++;
    end
    wr_valid = 1'b0;
  endtask

  task automatic std_drain(input int n, input int base, input string tag);
    int j = 0, guard = 0;
    bit issue;
    while (j < n && guard < 4000) begin
      @(negedge rclk); issue = !empty; rd_en = issue; guard++;
      @(posedge rclk); #1;
      if (issue) begin chk(q == pat(base + j), tag, q, pat(base + j)); j++; end
    end
    @(negedge rclk); rd_en = 1'b0;
    chk(j == n, tag, j, n);
  endtask

  task automatic fwft_drain(input int n, input int base, input string tag);
    int j = 0, guard = 0;
    while (j < n && guard < 4000) begin
      @(negedge rclk); guard++;
      if (out_rdy) begin
        chk(q == pat(base + j), tag, q, pat(base + j));
        rd_en = 1'b1; j++;
      end else rd_en = 1'b0;
    end
    @(negedge rclk); rd_en = 1'b0;
    chk(j == n, tag, j, n);
  endtask

  initial begin
    int taken;
    logic [17:0] held;
    bit fw;

    // ---------- standard mode ----------
    do_reset(3'b001);
    chk(empty == 1'b1, "R4 empty after reset", empty, 1);
    chk(wr_ready == 1'b1, "R12 ready after reset", wr_ready, 1);
    chk(out_rdy == 1'b0, "R11 out_rdy low in standard", out_rdy, 0);
    chk(q == 18'h0, "R6 output after reset", q, 0);

    write_one(pat(0));
    redges(1);
    chk(empty == 1'b1, "R4 empty not early", empty, 1);
    redges(2);
    chk(empty == 1'b0, "R4 empty released", empty, 0);
    chk(q == 18'h0, "R6 no read, no load", q, 0);
    std_drain(1, 0, "R5 single read");
    redges(2);
    chk(empty == 1'b1, "R5 empty after last read", empty, 1);

    // full sweep: DEPTH words, overflow attempt, drain in order
    do_reset(3'b101);
    fill(DEPTH, taken);
    chk(taken == DEPTH, "R1 accepted words", taken, DEPTH);
    chk(wr_ready == 1'b0, "R12 full at depth", wr_ready, 0);
    @(negedge wclk); wr_valid = 1'b1; wr_data = 18'h3ffff;
    repeat (4) @(negedge wclk);
    wr_valid = 1'b0;
    chk(wr_ready == 1'b0, "R3 stays full under offer", wr_ready, 0);
    std_drain(DEPTH, 0, "R1 R3 R5 order");
    repeat (6) @(negedge wclk);
    chk(wr_ready == 1'b1, "R12 ready after drain", wr_ready, 1);
    redges(2);
    chk(empty == 1'b1, "R5 empty after drain", empty, 1);

    // reads against empty are ignored
    held = q;
    @(negedge rclk); rd_en = 1'b1;
    redges(3);
    @(negedge rclk); rd_en = 1'b0;
    chk(q == held, "R6 read while empty keeps q", q, held);
    chk(empty == 1'b1, "R6 still empty", empty, 1);
    write_one(pat(300));
    redges(5);
    chk(q == held, "R6 q holds without read", q, held);
    std_drain(1, 300, "R6 pointer intact");

    // output enable
    write_one(pat(301));
    redges(5);
    std_drain(1, 301, "R10 word before disable");
    @(negedge rclk); out_en = 1'b0; #1;
    chk(q !== pat(301), "R10 bus released", q, pat(301));
    chk(empty == 1'b1, "R10 flags unaffected", empty, 1);
    @(negedge rclk); out_en = 1'b1; #1;
    chk(q == pat(301), "R10 bus driven again", q, pat(301));

    // ---------- fall-through mode ----------
    do_reset(3'b010);
    chk(out_rdy == 1'b0, "R7 out_rdy after reset", out_rdy, 0);
    chk(empty == 1'b1, "R11 empty held in fall-through", empty, 1);
    write_one(pat(0));
    redges(1);
    chk(out_rdy == 1'b0, "R7 out_rdy not early", out_rdy, 0);
    redges(3);
    chk(out_rdy == 1'b1, "R7 out_rdy raised", out_rdy, 1);
    chk(q == pat(0), "R7 word fell through", q, pat(0));
    redges(4);
    chk(q == pat(0) && out_rdy, "R9 held without request", q, pat(0));
    fwft_drain(1, 0, "R8 pop single");
    redges(2);
    chk(out_rdy == 1'b0, "R8 out_rdy falls when empty", out_rdy, 0);
    @(negedge rclk); rd_en = 1'b1;
    redges(3);
    @(negedge rclk); rd_en = 1'b0;
    chk(out_rdy == 1'b0, "R9 request while not ready ignored", out_rdy, 0);
    write_one(pat(500));
    redges(6);
    chk(q == pat(500), "R9 pointer intact", q, pat(500));
    fwft_drain(1, 500, "R8 pop after ignored request");

    // fall-through full sweep: capacity DEPTH+1
    do_reset(3'b110);
    fill(DEPTH + 8, taken);
    chk(taken == DEPTH + 1, "R9 fall-through capacity", taken, DEPTH + 1);
    fwft_drain(DEPTH + 1, 0, "R1 R8 fall-through order");
    redges(3);
    chk(out_rdy == 1'b0, "R8 drained", out_rdy, 0);

    // ---------- strap sweep ----------
    for (int code = 0; code < 8; code++) begin
      do_reset(code[2:0]);
      fw = (code == 2) || (code == 6);
      write_one(pat(code + 40));
      redges(6);
      chk(out_rdy == fw, $sformatf("R2 code %0d out_rdy", code), out_rdy, fw);
      chk(empty == fw, $sformatf("R2 R11 code %0d empty", code), empty, fw);
      chk(q == (fw ? pat(code + 40) : 18'h0), $sformatf("R2 code %0d q", code),
          q, fw ? pat(code + 40) : 18'h0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule